// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time for a chip from a slow 32.768 kHz clock-enable. A prescaler counts enable pulses and produces a one-second tick. The tick advances a chain of counters for seconds, minutes, hours and a 15-bit day count. The same tick drives a countdown stopwatch with one-second resolution. It also triggers two alarm comparators. One alarm compares only the time of day. The other compares the day count and its own time of day.

Every event sets a sticky bit in a status register. Each status bit has its own enable bit. The level interrupt `irq` is high while any enabled status bit is set. The output `wake` gives a one-cycle pulse in each cycle in which an enabled event occurs.

Software reaches the block through a single-cycle register port. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`.

The stopwatch is a two-state machine:
- **IDLE** is the reset state. The transition *arm* (a load with a nonzero value) moves it to RUN.
- **RUN** counts down by one on each second. The transition *expire* (a second tick while the count is 1) sets the count to 0, raises the stopwatch event and returns to IDLE.
- **RUN** also has the transitions *reload* (a nonzero load, staying in RUN) and *cancel* (a load of zero, going to IDLE).

Top module: `rtc_calendar`

## Requirements
- R1: After reset every register reads zero: time (address 0), day (1), stopwatch (5), interrupt enable (6) and status (7). `irq` and `wake` are low.
- R2: The seconds field advances by one only after exactly PRESCALE cycles in which `tick_en` is high. Cycles with `tick_en` low do not count.
- R3: A write to the time register (address 0) or the day register (address 1) clears the prescaler. The next second then needs a full PRESCALE enables.
- R4: The time register holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and increment the day (address 1, bits 14:0). All of these change on the same tick, and the day wraps from 32767 to 0.
- R5: On each second tick the status register sets bit 0. It also sets bit 1 on a minute change, bit 2 on an hour change and bit 3 on a day change.
- R6: A status bit, once set, stays set until software clears it.
- R7: Writing the status register (address 7) clears each bit written as 1 and leaves the other bits unchanged. An event in the same cycle wins over the clear.
- R8: `irq` is high exactly when some status bit is set whose bit in the enable register (address 6, same bit order) is also 1.
- R9: `wake` pulses for one cycle, once for each cycle in which at least one enabled event occurs.
- R10: Writing N to the stopwatch register (address 5, bits 15:0) makes it count down once per second. When it reaches 0, it sets status bit 4. Writing 0 stops the stopwatch without an event.
- R11: After reaching zero, the stopwatch stays at 0 and raises no further event until it is written again.
- R12: Alarm 1 (time-of-day register at address 2, time layout) sets status bit 5 on any second advance that lands on its time, whatever the day.
- R13: Alarm 2 (time at address 3, day at address 4) sets status bit 6 only when both the time and the day match after a second advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32.768 kHz clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Level interrupt: an enabled status bit is set |
| wake | output | 1 | One-cycle pulse on an enabled event |

## Verification
Three situations are hard to reach from the ports: the day wrapping from 32767 to 0, the full carry chain rippling on one tick, and day-qualified alarm matches. At the real rate they are many simulated days away. The bench shortens the prescaler to four enables and preloads the time and day a few seconds before each boundary. It then feeds enables with random gaps, so both the carry chain and the prescaler restart are exercised. Random trials place both alarms and the stopwatch expiry within the same short window. A bench model then checks the status bits, the interrupt and the count of wake pulses.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_EVT = 7;

    // register addresses
    localparam logic [2:0] A_TIME    = 3'd0;
    localparam logic [2:0] A_DAY     = 3'd1;
    localparam logic [2:0] A_ALM1    = 3'd2;
    localparam logic [2:0] A_ALM2    = 3'd3;
    localparam logic [2:0] A_ALM2DAY = 3'd4;
    localparam logic [2:0] A_SW      = 3'd5;
    localparam logic [2:0] A_IEN     = 3'd6;
    localparam logic [2:0] A_STAT    = 3'd7;

    // event bit positions
    localparam int EV_SEC  = 0;
    localparam int EV_MIN  = 1;
    localparam int EV_HOUR = 2;
    localparam int EV_DAY  = 3;
    localparam int EV_SW   = 4;
    localparam int EV_ALM1 = 5;
    localparam int EV_ALM2 = 6;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    typedef enum logic [0:0] {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sw_state_e;

    function automatic logic [REG_W-1:0] tod_to_word(tod_t t);
        return {11'd0, t.hr, 2'd0, t.min, 2'd0, t.sec};
    endfunction

    function automatic tod_t word_to_tod(logic [REG_W-1:0] w);
        tod_t t;
        t.hr  = w[20:16];
        t.min = w[13:8];
        t.sec = w[5:0];
        return t;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clr,
    output logic sec_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last  = (cnt_q == LAST);
    assign sec_tick = tick_en && at_last && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_cal_pkg::*;
#(
    parameter int DAY_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             ld_tod,
    input  tod_t             tod_in,
    input  logic             ld_day,
    input  logic [DAY_W-1:0] day_in,
    output tod_t             tod_q,
    output logic [DAY_W-1:0] day_q,
    output logic             roll_min,
    output logic             roll_hr,
    output logic             roll_day
);
    logic wrap_s, wrap_m, wrap_h;

    assign wrap_s   = sec_tick && (tod_q.sec == 6'd59);
    assign wrap_m   = wrap_s   && (tod_q.min == 6'd59);
    assign wrap_h   = wrap_m   && (tod_q.hr  == 5'd23);
    assign roll_min = wrap_s;
    assign roll_hr  = wrap_m;
    assign roll_day = wrap_h;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tod_q <= '0;
        end else if (ld_tod) begin
            tod_q <= tod_in;
        end else if (sec_tick) begin
            tod_q.sec <= wrap_s ? 6'd0 : tod_q.sec + 6'd1;
            if (wrap_s) tod_q.min <= wrap_m ? 6'd0 : tod_q.min + 6'd1;
            if (wrap_m) tod_q.hr  <= wrap_h ? 5'd0 : tod_q.hr + 5'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            day_q <= '0;
        end else if (ld_day) begin
            day_q <= day_in;
        end else if (wrap_h) begin
            day_q <= day_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch
    import rtc_cal_pkg::*;
#(
    parameter int SW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sec_tick,
    input  logic            load,
    input  logic [SW_W-1:0] load_val,
    output logic [SW_W-1:0] count,
    output logic            expire
);
    localparam logic [SW_W-1:0] ONE = SW_W'(1);

    sw_state_e state_q, state_d;
    logic      load_nz;

    assign load_nz = (load_val != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    // next state and event output
    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        unique case (state_q)
            SW_IDLE: begin
                if (load && load_nz) state_d = SW_RUN;       // arm
            end
            SW_RUN: begin
                if (load) begin
                    state_d = load_nz ? SW_RUN : SW_IDLE;   // reload / cancel
                end else if (sec_tick && count == ONE) begin
                    state_d = SW_IDLE;                      // expire
                    expire  = 1'b1;
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (state_q == SW_RUN && sec_tick) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE = 32768,
    parameter int DAY_W    = 15,
    parameter int SW_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        wake
);
    logic time_wr, day_wr, sw_wr, stat_wr;
    logic presc_clr, sec_tick, tick_d;
    logic roll_min, roll_hr, roll_day, sw_expire;
    logic alm1_hit, alm2_hit;

    tod_t             tod_q;
    logic [DAY_W-1:0] day_q;
    logic [SW_W-1:0]  sw_count;
    tod_t             alm1_q, alm2_q;
    logic [DAY_W-1:0] alm2_day_q;
    logic [NUM_EVT-1:0] irq_en_q, stat_q, evt;
    logic [5:0] cur_sec, cur_min;
    logic       unused_wdata;

    assign time_wr   = wr_en && (addr == A_TIME);
    assign day_wr    = wr_en && (addr == A_DAY);
    assign sw_wr     = wr_en && (addr == A_SW);
    assign stat_wr   = wr_en && (addr == A_STAT);
    assign presc_clr = time_wr || day_wr;
    assign cur_sec   = tod_q.sec;
    assign cur_min   = tod_q.min;
    assign unused_wdata = ^wdata[31:21];

    rtc_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .clr      (presc_clr),
        .sec_tick (sec_tick)
    );

    rtc_timekeeper #(.DAY_W(DAY_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .ld_tod   (time_wr),
        .tod_in   (word_to_tod(wdata)),
        .ld_day   (day_wr),
        .day_in   (wdata[DAY_W-1:0]),
        .tod_q    (tod_q),
        .day_q    (day_q),
        .roll_min (roll_min),
        .roll_hr  (roll_hr),
        .roll_day (roll_day)
    );

    rtc_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .load     (sw_wr),
        .load_val (wdata[SW_W-1:0]),
        .count    (sw_count),
        .expire   (sw_expire)
    );

    // software-held settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm1_q     <= '0;
            alm2_q     <= '0;
            alm2_day_q <= '0;
            irq_en_q   <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_ALM1:    alm1_q     <= word_to_tod(wdata);
                A_ALM2:    alm2_q     <= word_to_tod(wdata);
                A_ALM2DAY: alm2_day_q <= wdata[DAY_W-1:0];
                A_IEN:     irq_en_q   <= wdata[NUM_EVT-1:0];
                default: ;
            endcase
        end
    end

    // alarms compare the time one cycle after it advanced
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_d <= 1'b0;
        else        tick_d <= sec_tick;
    end

    assign alm1_hit = tick_d && (tod_q == alm1_q);
    assign alm2_hit = tick_d && (tod_q == alm2_q) && (day_q == alm2_day_q);

    always_comb begin
        evt          = '0;
        evt[EV_SEC]  = sec_tick;
        evt[EV_MIN]  = roll_min;
        evt[EV_HOUR] = roll_hr;
        evt[EV_DAY]  = roll_day;
        evt[EV_SW]   = sw_expire;
        evt[EV_ALM1] = alm1_hit;
        evt[EV_ALM2] = alm2_hit;
    end

    // sticky status, write-one-to-clear, event wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            wake   <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~(stat_wr ? wdata[NUM_EVT-1:0] : '0)) | evt;
            wake   <= |(evt & irq_en_q);
        end
    end

    assign irq = |(stat_q & irq_en_q);

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_TIME:    rdata = tod_to_word(tod_q);
            A_DAY:     rdata[DAY_W-1:0] = day_q;
            A_ALM1:    rdata = tod_to_word(alm1_q);
            A_ALM2:    rdata = tod_to_word(alm2_q);
            A_ALM2DAY: rdata[DAY_W-1:0] = alm2_day_q;
            A_SW:      rdata[SW_W-1:0] = sw_count;
            A_IEN:     rdata[NUM_EVT-1:0] = irq_en_q;
            A_STAT:    rdata[NUM_EVT-1:0] = stat_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int SW_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_en,
    input logic            wr_en,
    input logic [2:0]      addr,
    input logic            irq,
    input logic            wake,
    input logic [6:0]      irq_en_q,
    input logic [6:0]      stat_q,
    input logic [5:0]      cur_sec,
    input logic [5:0]      cur_min,
    input logic [SW_W-1:0] sw_count
);
    a_r2_sec_holds_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(wr_en && addr == A_TIME)) |=> $stable(cur_sec));

    a_r4_min_moves_on_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == A_TIME) && cur_sec != 6'd59) |=> $stable(cur_min));

    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    a_r8_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_q == 7'd0) |-> !irq);

    a_r9_wake_leaves_status: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (stat_q != 7'd0));

    a_r10_sw_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_SW) |=>
            (sw_count == $past(sw_count) || sw_count == $past(sw_count) - 1'b1));

    a_r11_sw_rests_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_count == '0 && !(wr_en && addr == A_SW)) |=> (sw_count == '0));
endmodule

bind rtc_calendar rtc_calendar_chk #(.SW_W(SW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .irq      (irq),
    .wake     (wake),
    .irq_en_q (irq_en_q),
    .stat_q   (stat_q),
    .cur_sec  (cur_sec),
    .cur_min  (cur_min),
    .sw_count (sw_count)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
    localparam int CLK_PERIOD = 10;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wake;

    int n_tests = 0, n_fail = 0, wake_cnt = 0, exp_wake = 0;
    bit done = 1'b0;

    // model state
    int m_sec, m_min, m_hr, m_day, m_sw;
    int a1h, a1m, a1s, a2h, a2m, a2s, a2d;
    logic [6:0] m_stat, m_en;

    rtc_calendar #(.PRESCALE(PS)) i_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (wake) wake_cnt++;

    function automatic logic [31:0] tw(int h, int m, int s);
        return {11'd0, 5'(h), 2'd0, 6'(m), 2'd0, 6'(s)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_time(int h, int m, int s);
        wr(3'd0, tw(h, m, s)); m_hr = h; m_min = m; m_sec = s;
    endtask
    task automatic set_day(int d);
        wr(3'd1, 32'(d)); m_day = d;
    endtask
    task automatic set_alm1(int h, int m, int s);
        wr(3'd2, tw(h, m, s)); a1h = h; a1m = m; a1s = s;
    endtask
    task automatic set_alm2(int h, int m, int s, int d);
        wr(3'd3, tw(h, m, s)); wr(3'd4, 32'(d));
        a2h = h; a2m = m; a2s = s; a2d = d;
    endtask
    task automatic set_sw(int n);
        wr(3'd5, 32'(n)); m_sw = n;
    endtask
    task automatic set_en(logic [6:0] e);
        wr(3'd6, {25'd0, e}); m_en = e;
    endtask
    task automatic clr_stat(logic [6:0] c);
        wr(3'd7, {25'd0, c}); m_stat = m_stat & ~c;
    endtask

    task automatic give_enables(int n);
        int got = 0;
        while (got < n) begin
            @(negedge clk);
            if ($urandom % 4 != 0) begin tick_en = 1'b1; got++; end
            else tick_en = 1'b0;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic model_second();
        logic [6:0] et = 7'b1, ea = 7'b0;
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; et[1] = 1'b1; m_min++;
            if (m_min == 60) begin
                m_min = 0; et[2] = 1'b1; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0; et[3] = 1'b1; m_day = (m_day + 1) % 32768;
                end
            end
        end
        if (m_sw > 0) begin m_sw--; if (m_sw == 0) et[4] = 1'b1; end
        if (m_hr == a1h && m_min == a1m && m_sec == a1s) ea[5] = 1'b1;
        if (m_hr == a2h && m_min == a2m && m_sec == a2s && m_day == a2d) ea[6] = 1'b1;
        m_stat = m_stat | et | ea;
        if ((et & m_en) != 0) exp_wake++;
        if ((ea & m_en) != 0) exp_wake++;
    endtask

    task automatic advance(int n);
        for (int i = 0; i < n; i++) begin
            give_enables(PS);
            model_second();
        end
        @(negedge clk); @(negedge clk);
    endtask

    task automatic check_model(string tag);
        logic [31:0] d;
        rd(3'd0, d); chk({tag, " R4 time"}, d, tw(m_hr, m_min, m_sec));
        rd(3'd1, d); chk({tag, " R4 day"}, d, 32'(m_day));
        rd(3'd7, d); chk({tag, " R5/R6 status"}, d, {25'd0, m_stat});
        rd(3'd5, d); chk({tag, " R10 stopwatch"}, d, 32'(m_sw));
        chk({tag, " R8 irq"}, {31'd0, irq}, {31'd0, |(m_stat & m_en)});
        chk({tag, " R9 wake count"}, 32'(wake_cnt), 32'(exp_wake));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_sw = 0;
        a1h = 0; a1m = 0; a1s = 0; a2h = 0; a2m = 0; a2s = 0; a2d = 0;
        m_stat = '0; m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset
        rd(3'd0, d); chk("R1 time reset", d, 0);
        rd(3'd1, d); chk("R1 day reset", d, 0);
        rd(3'd5, d); chk("R1 stopwatch reset", d, 0);
        rd(3'd6, d); chk("R1 enable reset", d, 0);
        rd(3'd7, d); chk("R1 status reset", d, 0);
        chk("R1 irq/wake reset", {30'd0, irq, wake}, 0);

        // keep alarms away from the directed windows
        set_alm1(12, 0, 0);
        set_alm2(12, 0, 0, 5);

        // R2 prescale spacing
        advance(1);
        check_model("R2 first second");
        give_enables(PS - 1); @(negedge clk);
        rd(3'd0, d); chk("R2 one enable short", d, tw(0, 0, 1));
        give_enables(1); model_second(); @(negedge clk);
        rd(3'd0, d); chk("R2 full count", d, tw(0, 0, 2));

        // R3 prescaler restart on time write
        give_enables(2);
        set_time(10, 20, 30);
        give_enables(PS - 1); @(negedge clk);
        rd(3'd0, d); chk("R3 restart holds", d, tw(10, 20, 30));
        give_enables(1); model_second(); @(negedge clk);
        rd(3'd0, d); chk("R3 restart then step", d, tw(10, 20, 31));

        // R4/R5 full ripple with day wrap
        clr_stat(7'h7f);
        set_day(32767);
        set_time(23, 59, 59);
        advance(1);
        rd(3'd0, d); chk("R4 ripple time", d, 0);
        rd(3'd1, d); chk("R4 day wrap", d, 0);
        rd(3'd7, d); chk("R5 rollover bits", d, 32'h0f);

        // R7 write-one-to-clear
        clr_stat(7'h02);
        rd(3'd7, d); chk("R7 clear one bit", d, 32'h0d);

        // R8 enable gating
        chk("R8 masked", {31'd0, irq}, 0);
        set_en(7'h04); #1;
        chk("R8 enabled pending", {31'd0, irq}, 1);
        set_en(7'h02); #1;
        chk("R8 enabled but clear", {31'd0, irq}, 0);

        // R9 wake pulses
        clr_stat(7'h7f);
        set_en(7'h01);
        advance(3);
        chk("R9 wake per second", 32'(wake_cnt), 32'(exp_wake));

        // R10/R11 stopwatch
        set_en(7'h10);
        clr_stat(7'h7f);
        set_sw(3);
        advance(2);
        rd(3'd5, d); chk("R10 counting", d, 1);
        rd(3'd7, d); chk("R10 not yet", {31'd0, d[4]}, 0);
        advance(1);
        rd(3'd5, d); chk("R10 reached zero", d, 0);
        rd(3'd7, d); chk("R10 event", {31'd0, d[4]}, 1);
        clr_stat(7'h7f);
        advance(2);
        rd(3'd5, d); chk("R11 stays zero", d, 0);
        rd(3'd7, d); chk("R11 no repeat", {31'd0, d[4]}, 0);
        set_sw(0);
        advance(1);
        rd(3'd7, d); chk("R10 zero load no event", {31'd0, d[4]}, 0);

        // R12/R13 alarms
        clr_stat(7'h7f);
        set_day(7); set_time(8, 0, 0);
        set_alm1(8, 0, 2); set_alm2(8, 0, 2, 8);
        advance(2);
        rd(3'd7, d); chk("R12 alarm1 hit", {31'd0, d[5]}, 1);
        chk("R13 alarm2 day mismatch", {31'd0, d[6]}, 0);
        clr_stat(7'h7f);
        set_day(100); set_time(8, 0, 0);
        set_alm2(8, 0, 2, 100);
        advance(2);
        rd(3'd7, d); chk("R12 alarm1 other day", {31'd0, d[5]}, 1);
        chk("R13 alarm2 both match", {31'd0, d[6]}, 1);
        check_model("R13 model");

        // random trials near boundaries
        for (int t = 0; t < 8; t++) begin
            int h, mi, s, dy, k, tot;
            h  = $urandom % 24;
            mi = 57 + $urandom % 3;
            s  = 50 + $urandom % 10;
            dy = ($urandom % 2) ? 32767 : $urandom % 32768;
            set_day(dy);
            set_time(h, mi, s);
            k = 1 + $urandom % 12;
            tot = h * 3600 + mi * 60 + s + k;
            set_alm1((tot / 3600) % 24, (tot / 60) % 60, tot % 60);
            k = 1 + $urandom % 12;
            tot = h * 3600 + mi * 60 + s + k;
            set_alm2((tot / 3600) % 24, (tot / 60) % 60, tot % 60,
                     ((tot >= 86400) ? (dy + 1) % 32768 : dy) ^ ($urandom % 2));
            set_sw($urandom % 6);
            set_en(7'($urandom));
            clr_stat(7'h7f);
            advance(1 + $urandom % 12);
            check_model("R6 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule